// File: doc/BRIEF.md
# Serial Transmitter with Line Control and Baud Divisor

This block is the sending half of a byte-oriented asynchronous serial port with a register map that is compatible with existing software. A host writes a line-settings register, a 16-bit baud divisor and bytes to send through a small register port. The block turns each byte into a serial frame: a low start bit, five to eight data bits least significant first, an optional parity bit and a high stop period of one, one and a half or two bit times. It reports through two status flags when the holding slot and the whole transmitter are empty.

Timing comes from the system clock alone. A divisor counter makes a one-cycle enable every N clocks, and each serial bit lasts sixteen such enables. The divisor shares register offsets 0 and 1 with the byte-to-send slot. The top bit of the line-settings register selects which of the two is reached. Setting the break bit holds the line low while the frame logic keeps running behind it.

Top module: `uart_tx_core`

## Requirements
- R1: After reset the serial output is 1, both empty flags are 1, the line-settings register reads 0x00, the divisor is 0 and the status register reads 0x60.
- R2: The line-settings register is at offset 3. While its bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte, and a write to offset 0 does not fill the holding slot. While bit 7 is 0, a write to offset 0 fills the holding slot, a write to offset 1 changes nothing, and both offsets read 0x00.
- R3: With divisor N ≥ 1 every serial bit lasts 16·N clocks. With divisor 0 no enable occurs, a written byte stays in the holding slot and the output stays at 1.
- R4: A frame is a 0 start bit, then the data bits least significant first, then a 1 stop period. The count of data bits is set by line-settings bits [1:0]: 00, 01, 10 and 11 give 5, 6, 7 and 8.
- R5: Line-settings bits {5,4,3} = {stick, even, enable} choose the parity bit: x,x,0 gives no parity bit; 0,0,1 gives odd parity over the data bits; 0,1,1 gives even parity; 1,0,1 gives a constant 1; 1,1,1 gives a constant 0.
- R6: Line-settings bit 2 = 0 gives a 16-enable stop period. Bit 2 = 1 gives 24 enables with 5-bit words and 32 enables with 6-, 7- or 8-bit words.
- R7: While line-settings bit 6 is 1, the output is 0 from the second clock after the write. Frames still advance and empty the transmitter. Clearing the bit returns the output to the frame line within two clocks.
- R8: thr_empty is 1 when the holding slot is free. tx_empty is 1 only when both the holding slot and the shifter are idle. The status register at offset 5 shows thr_empty in bit 5 and tx_empty in bit 6, and the other bits are 0.
- R9: A byte written while a frame is in flight starts at the exact end of that frame's stop period, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Registered read data, valid one clock after rd_addr |
| txd | output | 1 | Serial output, idle high |
| thr_empty | output | 1 | Holding slot free |
| tx_empty | output | 1 | Holding slot and shifter both idle |

## Verification
A wrong bit counter or wrong latched word settings shows at txd within one frame: data bits move, the parity bit is wrong, or the stop period is too short or too long. These faults are caught by sampling at bit centres and by timing the start-to-start distance of back-to-back frames, so they appear in the next frame that is sent. A wrong divisor count or wrong register banking shows within a few clocks as a wrong read-back value, or as a byte that should or should not leave the holding slot. A stuck empty flag shows on the status port as soon as a byte is written or a frame ends.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] OFS_DATA = 3'd0;
  localparam logic [REG_AW-1:0] OFS_HIGH = 3'd1;
  localparam logic [REG_AW-1:0] OFS_LINE = 3'd3;
  localparam logic [REG_AW-1:0] OFS_STAT = 3'd5;

  typedef struct packed {
    logic       bank;   // divisor access select
    logic       brk;    // force line low
    logic       stick;  // constant parity
    logic       even;   // even / constant-0 select
    logic       pen;    // parity bit present
    logic       stop2;  // long stop period
    logic [1:0] wlen;   // 5..8 data bits
  } line_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_t;

endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              load,
  input  logic              busy,
  output line_cfg_t         cfg,
  output logic [DIV_W-1:0]  divisor,
  output logic [7:0]        thr_data,
  output logic              thr_full
);

  localparam int HI_W = DIV_W - 8;

  logic [7:0]      div_lo;
  logic [HI_W-1:0] div_hi;
  logic            wr_thr;

  assign divisor = {div_hi, div_lo};
  assign wr_thr  = wr_en && (wr_addr == OFS_DATA) && !cfg.bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg    <= '0;
      div_lo <= '0;
      div_hi <= '0;
    end else if (wr_en) begin
      if (wr_addr == OFS_LINE) cfg <= line_cfg_t'(wr_data);
      if (wr_addr == OFS_DATA && cfg.bank) div_lo <= wr_data;
      if (wr_addr == OFS_HIGH && cfg.bank) div_hi <= wr_data[HI_W-1:0];
    end
  end

  // holding slot: a new write wins over a same-cycle load
  always_ff @(posedge clk) begin
    if (rst) begin
      thr_full <= 1'b0;
      thr_data <= '0;
    end else if (wr_thr) begin
      thr_full <= 1'b1;
      thr_data <= wr_data;
    end else if (load) begin
      thr_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        OFS_DATA: rd_data <= cfg.bank ? div_lo : 8'h00;
        OFS_HIGH: rd_data <= cfg.bank ? 8'(div_hi) : 8'h00;
        OFS_LINE: rd_data <= cfg;
        OFS_STAT: rd_data <= {1'b0, !thr_full && !busy, !thr_full, 5'b0};
        default:  rd_data <= 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (divisor == '0) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= divisor - 1'b1) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      thr_full,
  input  logic [7:0] thr_data,
  input  line_cfg_t cfg,
  output logic      load,
  output logic      line,
  output logic      busy
);

  localparam int CW = $clog2(2 * OVS);
  localparam logic [CW-1:0] BIT_LAST  = CW'(OVS - 1);
  localparam logic [CW-1:0] STOP_MID  = CW'((OVS * 3) / 2 - 1);
  localparam logic [CW-1:0] STOP_LONG = CW'(2 * OVS - 1);

  tx_state_t     state;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [2:0]    last_q;
  logic [7:0]    shreg;
  logic          pen_q;
  logic          par_q;
  logic [CW-1:0] stop_q;

  logic [2:0]    last_n;
  logic [7:0]    mask;
  logic          par_x;
  logic          par_n;
  logic [CW-1:0] stop_n;
  logic          at_end;

  // settings captured at frame load
  always_comb begin
    last_n = {1'b1, cfg.wlen};
    for (int i = 0; i < 8; i++) mask[i] = (3'(i) <= last_n);
    par_x  = ^(thr_data & mask);
    par_n  = cfg.stick ? !cfg.even : (cfg.even ? par_x : !par_x);
    if (!cfg.stop2)            stop_n = BIT_LAST;
    else if (cfg.wlen == 2'b00) stop_n = STOP_MID;
    else                       stop_n = STOP_LONG;
  end

  assign at_end = (state == ST_STOP) && (cnt == stop_q);
  assign load   = tick && thr_full && ((state == ST_IDLE) || at_end);
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      last_q <= 3'd7;
      shreg  <= '0;
      pen_q  <= 1'b0;
      par_q  <= 1'b0;
      stop_q <= BIT_LAST;
      line   <= 1'b1;
    end else if (tick) begin
      if (load) begin
        state  <= ST_START;
        cnt    <= '0;
        line   <= 1'b0;
        shreg  <= thr_data;
        last_q <= last_n;
        pen_q  <= cfg.pen;
        par_q  <= par_n;
        stop_q <= stop_n;
      end else begin
        case (state)
          ST_START: begin
            if (cnt == BIT_LAST) begin
              state <= ST_DATA;
              cnt   <= '0;
              bitn  <= '0;
              line  <= shreg[0];
            end else cnt <= cnt + 1'b1;
          end
          ST_DATA: begin
            if (cnt == BIT_LAST) begin
              cnt <= '0;
              if (bitn == last_q) begin
                state <= pen_q ? ST_PAR : ST_STOP;
                line  <= pen_q ? par_q : 1'b1;
              end else begin
                bitn  <= bitn + 1'b1;
                shreg <= shreg >> 1;
                line  <= shreg[1];
              end
            end else cnt <= cnt + 1'b1;
          end
          ST_PAR: begin
            if (cnt == BIT_LAST) begin
              state <= ST_STOP;
              cnt   <= '0;
              line  <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            if (at_end) begin
              state <= ST_IDLE;
              cnt   <= '0;
              line  <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          default: begin
            state <= ST_IDLE;
            line  <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       txd,
  output logic       thr_empty,
  output logic       tx_empty
);

  line_cfg_t        cfg_w;
  logic [DIV_W-1:0] div_w;
  logic [7:0]       thr_data_w;
  logic             thr_full_w;
  logic             tick_w;
  logic             load_w;
  logic             line_w;
  logic             busy_w;

  uart_tx_regs #(.DIV_W(DIV_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .load     (load_w),
    .busy     (busy_w),
    .cfg      (cfg_w),
    .divisor  (div_w),
    .thr_data (thr_data_w),
    .thr_full (thr_full_w)
  );

  uart_tx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk     (clk),
    .rst     (rst),
    .divisor (div_w),
    .tick    (tick_w)
  );

  uart_tx_shifter #(.OVS(OVS)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_w),
    .thr_full (thr_full_w),
    .thr_data (thr_data_w),
    .cfg      (cfg_w),
    .load     (load_w),
    .line     (line_w),
    .busy     (busy_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      txd       <= 1'b1;
      thr_empty <= 1'b1;
      tx_empty  <= 1'b1;
    end else begin
      txd       <= line_w && !cfg_w.brk;
      thr_empty <= !thr_full_w;
      tx_empty  <= !thr_full_w && !busy_w;
    end
  end

endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic             txd,
  input logic             thr_empty,
  input logic             tx_empty,
  input logic [7:0]       cfg,
  input logic [DIV_W-1:0] divisor,
  input logic             tick,
  input logic             thr_full,
  input logic             busy
);

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    cfg[6] |=> !txd); // R7

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cfg[6]) |=> txd); // R4

  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> thr_empty); // R8

  AST_ZERO_DIV_QUIET: assert property (@(posedge clk) disable iff (rst)
    (divisor == '0) |=> !tick); // R3

  AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(thr_full) |-> $past(tick)); // R3

  AST_BANK_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd0 && cfg[7] && !thr_full) |=> !thr_full); // R2

endmodule

bind uart_tx_core uart_tx_core_chk #(.DIV_W(DIV_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .txd       (txd),
  .thr_empty (thr_empty),
  .tx_empty  (tx_empty),
  .cfg       (cfg_w),
  .divisor   (div_w),
  .tick      (tick_w),
  .thr_full  (thr_full_w),
  .busy      (busy_w)
);

// File: tb/uart_tx_core_tb_top.sv
module uart_tx_core_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       txd, thr_empty, tx_empty;

  int  total = 0;
  int  bad   = 0;
  longint cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_tx_core dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .txd(txd),
    .thr_empty(thr_empty), .tx_empty(tx_empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic set_div(input int div, input logic [7:0] lcr);
    wr(3'd3, lcr | 8'h80);
    wr(3'd0, 8'(div));
    wr(3'd1, 8'(div >> 8));
    wr(3'd3, lcr);
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    while (tx_empty !== 1'b1) @(negedge clk);
  endtask

  // decode one frame at bit centres; t0 = cycle of start edge
  task automatic rx_frame(input int nb, input bit haspar, input int div,
                          output logic [7:0] d, output logic p,
                          output logic s, output longint t0);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    d  = '0;
    repeat (8 * div) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      repeat (16 * div) @(negedge clk);
      d[i] = txd;
    end
    p = 1'b0;
    if (haspar) begin
      repeat (16 * div) @(negedge clk);
      p = txd;
    end
    repeat (16 * div) @(negedge clk);
    s = txd;
  endtask

  function automatic logic exp_par(input int pm, input logic [7:0] d);
    case (pm)
      1: return ~^d;
      2: return ^d;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // pm: 0 none, 1 odd, 2 even, 3 const 1, 4 const 0
  task automatic send_pair(input int wl, input int pm, input int sb, input int div,
                           input logic [7:0] a, input logic [7:0] b, input string tag);
    logic [7:0] lcr, da, db, ma;
    logic pa, pb, sa, sbit;
    longint ta, tb;
    int nb, stopt, bits;
    nb = wl + 5;
    ma = 8'((1 << nb) - 1);
    lcr = {2'b00, (pm >= 3), (pm == 2 || pm == 4), (pm != 0), 1'(sb), 2'(wl)};
    wr(3'd3, lcr);
    fork
      begin
        rx_frame(nb, pm != 0, div, da, pa, sa, ta);
        rx_frame(nb, pm != 0, div, db, pb, sbit, tb);
      end
      begin
        wr(3'd0, a);
        repeat (4) @(negedge clk);
        while (thr_empty !== 1'b1) @(negedge clk);
        wr(3'd0, b);
      end
    join
    stopt = (sb == 0) ? 16 : ((wl == 0) ? 24 : 32);
    bits  = 1 + nb + ((pm != 0) ? 1 : 0);
    chk({tag, " R4 data a"}, 32'(da), 32'(a & ma));
    chk({tag, " R4 data b"}, 32'(db), 32'(b & ma));
    chk({tag, " R4 stop"}, {31'b0, sa & sbit}, 32'd1);
    if (pm != 0) begin
      chk({tag, " R5 parity a"}, {31'b0, pa}, {31'b0, exp_par(pm, a & ma)});
      chk({tag, " R5 parity b"}, {31'b0, pb}, {31'b0, exp_par(pm, b & ma)});
    end
    chk({tag, " R6 R9 frame period"}, 32'(tb - ta), 32'(div * (16 * bits + stopt)));
    wait_idle();
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=<150000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, d;
    logic p, s;
    longint t;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 txd", {31'b0, txd}, 32'd1);
    chk("R1 thr_empty", {31'b0, thr_empty}, 32'd1);
    chk("R1 tx_empty", {31'b0, tx_empty}, 32'd1);
    rd(3'd3, r); chk("R1 line reg", 32'(r), 32'h00);
    rd(3'd5, r); chk("R1 R8 status", 32'(r), 32'h60);

    // divisor 0: nothing moves
    wr(3'd0, 8'h5A);
    repeat (200) @(negedge clk);
    chk("R3 zero div txd", {31'b0, txd}, 32'd1);
    chk("R3 zero div held", {31'b0, thr_empty}, 32'd0);
    rd(3'd5, r); chk("R8 status pending", 32'(r), 32'h00);
    wr(3'd3, 8'h83);
    wr(3'd1, 8'h00);
    fork
      rx_frame(8, 1'b0, 1, d, p, s, t);
      wr(3'd0, 8'h01);
    join
    chk("R3 released frame", 32'(d), 32'h5A);
    chk("R3 released stop", {31'b0, s}, 32'd1);
    wait_idle();

    // banking
    wr(3'd0, 8'h34);
    wr(3'd1, 8'h12);
    repeat (3) @(negedge clk);
    chk("R2 bank no fill", {31'b0, thr_empty}, 32'd1);
    chk("R2 bank txd idle", {31'b0, txd}, 32'd1);
    rd(3'd0, r); chk("R2 div low", 32'(r), 32'h34);
    rd(3'd1, r); chk("R2 div high", 32'(r), 32'h12);
    rd(3'd3, r); chk("R2 line reg", 32'(r), 32'h83);
    wr(3'd3, 8'h03);
    wr(3'd1, 8'h77);
    rd(3'd1, r); chk("R2 offset1 unbanked read", 32'(r), 32'h00);
    rd(3'd0, r); chk("R2 offset0 unbanked read", 32'(r), 32'h00);
    chk("R2 offset1 write no fill", {31'b0, thr_empty}, 32'd1);
    wr(3'd3, 8'h83);
    rd(3'd1, r); chk("R2 div high kept", 32'(r), 32'h12);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h03);

    // full sweep at divisor 1
    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 5; pm++)
        for (int sb = 0; sb < 2; sb++)
          send_pair(wl, pm, sb, 1, 8'(wl * 37 + pm * 11 + sb * 5 + 8'h13),
                    8'(wl * 53 + pm * 29 + sb * 7 + 8'hA6), "sweep");

    // slower divisors
    set_div(3, 8'h03);
    send_pair(3, 2, 0, 3, 8'hC3, 8'h3C, "R3 div3");
    set_div(2, 8'h00);
    send_pair(0, 1, 1, 2, 8'h15, 8'h0A, "R3 div2");
    set_div(1, 8'h03);

    // status flags
    wr(3'd0, 8'h81);
    repeat (6) @(negedge clk);
    rd(3'd5, r); chk("R8 status shifting", 32'(r), 32'h20);
    chk("R8 tx_empty busy", {31'b0, tx_empty}, 32'd0);
    wr(3'd0, 8'h42);
    rd(3'd5, r); chk("R8 status both busy", 32'(r), 32'h00);
    wait_idle();
    rd(3'd5, r); chk("R8 status idle", 32'(r), 32'h60);

    // break
    wr(3'd3, 8'h43);
    @(negedge clk);
    chk("R7 break low", {31'b0, txd}, 32'd0);
    wr(3'd0, 8'hFF);
    repeat (250) @(negedge clk);
    chk("R7 break holds", {31'b0, txd}, 32'd0);
    chk("R7 shifter ran", {31'b0, tx_empty}, 32'd1);
    wr(3'd3, 8'h03);
    @(negedge clk);
    chk("R7 break release", {31'b0, txd}, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule